// File: doc/BRIEF.md
# Eight-Pin General-Purpose I/O Port with Event and Wake Reporting

This block gives software eight general-purpose pins. Each pin is set to drive or to sense, and has a polarity bit. An input can also run in a latched mode that records one chosen edge. Software reaches the port through a flat write/read register interface. The interface has a write strobe, an address and a write word. The read word is combinational and follows the address.

Every pad input passes through a two-flop synchronizer. Level changes are found by comparing the synchronized value with its copy from one cycle earlier. A change on an input pin can raise an event request. This needs two enables: the pin's own mask bit and a port-wide enable input. Events wait in per-pin pending flags until software acknowledges them. When the host link is reported down, a change on a wake-enabled input pin produces a one-cycle wake pulse.

Top module: `gpio8_event_port`

## Requirements
- R1: After reset, all pins are inputs (`pad_oe` = 0), all polarity bits are 1, and the output data, latched-mode, mask, wake-enable and pending registers are 0. `evt_req` and `wake_req` are low.
- R2: The register addresses are: 0 = data, 1 = direction (1 = output, drives `pad_oe`), 2 = polarity, 3 = latched-mode select, 4 = event mask, 5 = wake enable, 6 = pending events. Writes store `reg_wdata[7:0]`. Reads return the register in bits 7:0, with bits 31:8 zero. Any other address reads as zero.
- R3: For an output pin, `pad_out` equals the written data bit when polarity is 1, and its inverse when polarity is 0.
- R4: A data read of a plain input pin returns the synchronized pad value, inverted when polarity is 0. A pad change first shows in the read after the second rising clock edge.
- R5: A latched-mode input sets its latch on a rising edge of the synchronized pad when polarity is 1, and on a falling edge when polarity is 0. The opposite edge has no effect. A data read of that pin returns the latch. The latch sets at the third rising edge after the pad changes.
- R6: Writing 1 to a data bit clears that pin's latch, and writing 0 leaves it unchanged. A qualifying edge that arrives in the same cycle as the clear leaves the latch set.
- R7: An input pin whose synchronized level changes sets its pending bit at the third rising edge after the pad change, but only when both its mask bit and `unsol_en` are 1. `evt_req` is high while any pending bit is set.
- R8: A pending bit stays set until software writes 1 to it at address 6. Other bits are unaffected. A new change that arrives in the same cycle as that write keeps the bit set.
- R9: While `link_down` is 1, a level change on an input pin with its wake bit set gives a `wake_req` pulse one cycle long, at the same edge where a pending bit would set. No pulse occurs when `link_down` is 0 or the wake bit is 0. The pulse does not depend on the mask bit or on `unsol_en`.
- R10: For an output pin, a data read returns the written bit regardless of polarity, and pad activity on that pin raises no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Register write word |
| reg_rdata | output | 32 | Register read word for `reg_addr` |
| pad_in | input | 8 | Pad input levels, asynchronous |
| unsol_en | input | 1 | Port-wide event enable |
| link_down | input | 1 | Host link is inactive |
| pad_out | output | 8 | Pad output levels |
| pad_oe | output | 8 | Pad output enables |
| evt_req | output | 1 | At least one event is pending |
| wake_req | output | 1 | One-cycle wake pulse |

## Verification
Two functions can land in the same cycle: a software clear and a hardware set of the same bit. This happens when a latch clear meets a fresh qualifying edge, and when a pending acknowledge meets a new level change on that pin. The bench provokes both by issuing the clearing write exactly at the clock edge where the synchronized change registers, which is two cycles after the pad moves. It judges the result by reading the register back and expecting the bit still set. A second clear afterwards must then remove it.

// File: rtl/gpio8_pkg.sv
package gpio8_pkg;

  localparam int unsigned ADR_DATA  = 0;
  localparam int unsigned ADR_DIR   = 1;
  localparam int unsigned ADR_POL   = 2;
  localparam int unsigned ADR_LATCH = 3;
  localparam int unsigned ADR_MASK  = 4;
  localparam int unsigned ADR_WAKE  = 5;
  localparam int unsigned ADR_PEND  = 6;

  // Polarity 1 passes a bit through, polarity 0 inverts it.
  function automatic logic pol_view(input logic v, input logic pol);
    return pol ? v : ~v;
  endfunction

  // Edge selected by polarity: 1 picks rising, 0 picks falling.
  function automatic logic edge_hit(input logic prev, input logic cur,
                                    input logic pol);
    return pol ? (~prev & cur) : (prev & ~cur);
  endfunction

endpackage

// File: rtl/gpio8_sync.sv
module gpio8_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] cur,
  output logic [W-1:0] prev
);
  logic [W-1:0] s1, s2, s3;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= '0;
      s2 <= '0;
      s3 <= '0;
    end else begin
      s1 <= d_in;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign cur  = s2;
  assign prev = s3;
endmodule

// File: rtl/gpio8_cfg.sv
module gpio8_cfg
  import gpio8_pkg::*;
#(
  parameter int NPIN = 8,
  parameter int AW   = 4,
  parameter int DW   = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  output logic [NPIN-1:0] dir_q,
  output logic [NPIN-1:0] pol_q,
  output logic [NPIN-1:0] latch_q,
  output logic [NPIN-1:0] mask_q,
  output logic [NPIN-1:0] wake_q,
  output logic [NPIN-1:0] out_q,
  output logic [NPIN-1:0] stk_clr,
  output logic [NPIN-1:0] pend_clr
);
  logic [NPIN-1:0] wbits;
  logic            unused_hi;

  assign wbits     = wdata[NPIN-1:0];
  assign unused_hi = ^wdata[DW-1:NPIN];

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q   <= '0;
      pol_q   <= '1;
      latch_q <= '0;
      mask_q  <= '0;
      wake_q  <= '0;
      out_q   <= '0;
    end else if (we) begin
      case (addr)
        AW'(ADR_DATA):  out_q   <= wbits;
        AW'(ADR_DIR):   dir_q   <= wbits;
        AW'(ADR_POL):   pol_q   <= wbits;
        AW'(ADR_LATCH): latch_q <= wbits;
        AW'(ADR_MASK):  mask_q  <= wbits;
        AW'(ADR_WAKE):  wake_q  <= wbits;
        default: ;
      endcase
    end
  end

  // Write-one-to-clear strobes for the latches and the pending flags
  assign stk_clr  = (we && addr == AW'(ADR_DATA)) ? wbits : '0;
  assign pend_clr = (we && addr == AW'(ADR_PEND)) ? wbits : '0;
endmodule

// File: rtl/gpio8_pin_slice.sv
module gpio8_pin_slice
  import gpio8_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic cur,
  input  logic prev,
  input  logic dir,
  input  logic pol,
  input  logic latch_mode,
  input  logic mask,
  input  logic glob_en,
  input  logic out_bit,
  input  logic stk_clr,
  input  logic pend_clr,
  output logic pad_o,
  output logic rd_bit,
  output logic chg_o,
  output logic stk_hit,
  output logic stk_keep,
  output logic evt_set,
  output logic stk_o,
  output logic pend_o
);
  assign chg_o    = cur ^ prev;
  assign stk_keep = latch_mode & ~dir;
  assign stk_hit  = stk_keep & edge_hit(prev, cur, pol);
  assign evt_set  = ~dir & mask & glob_en & chg_o;
  assign pad_o    = pol_view(out_bit, pol);

  always_ff @(posedge clk) begin
    if (rst) begin
      stk_o  <= 1'b0;
      pend_o <= 1'b0;
    end else begin
      // set has priority over a clear in the same cycle
      if (stk_hit)       stk_o <= 1'b1;
      else if (!stk_keep) stk_o <= 1'b0;
      else if (stk_clr)  stk_o <= 1'b0;
      if (evt_set)       pend_o <= 1'b1;
      else if (pend_clr) pend_o <= 1'b0;
    end
  end

  always_comb begin
    if (dir)             rd_bit = out_bit;
    else if (latch_mode) rd_bit = stk_o;
    else                 rd_bit = pol_view(cur, pol);
  end
endmodule

// File: rtl/gpio8_event_port.sv
module gpio8_event_port
  import gpio8_pkg::*;
#(
  parameter int NPIN = 8,
  parameter int AW   = 4,
  parameter int DW   = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            reg_we,
  input  logic [AW-1:0]   reg_addr,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  input  logic [NPIN-1:0] pad_in,
  input  logic            unsol_en,
  input  logic            link_down,
  output logic [NPIN-1:0] pad_out,
  output logic [NPIN-1:0] pad_oe,
  output logic            evt_req,
  output logic            wake_req
);
  localparam int PADW = DW - NPIN;

  logic [NPIN-1:0] s_cur, s_prev;
  logic [NPIN-1:0] dir_q, pol_q, latch_q, mask_q, wake_q, out_q;
  logic [NPIN-1:0] stk_clr, pend_clr;
  logic [NPIN-1:0] rd_bits, chg_in, stk_hit, stk_keep, evt_set;
  logic [NPIN-1:0] stk_q, evt_pend;
  logic            wake_hit;
  logic [NPIN-1:0] rd_sel;

  gpio8_sync #(.W(NPIN)) u_sync (
    .clk(clk), .rst(rst), .d_in(pad_in), .cur(s_cur), .prev(s_prev)
  );

  gpio8_cfg #(.NPIN(NPIN), .AW(AW), .DW(DW)) u_cfg (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .dir_q(dir_q), .pol_q(pol_q), .latch_q(latch_q), .mask_q(mask_q),
    .wake_q(wake_q), .out_q(out_q), .stk_clr(stk_clr), .pend_clr(pend_clr)
  );

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    gpio8_pin_slice u_slice (
      .clk(clk), .rst(rst), .cur(s_cur[i]), .prev(s_prev[i]),
      .dir(dir_q[i]), .pol(pol_q[i]), .latch_mode(latch_q[i]),
      .mask(mask_q[i]), .glob_en(unsol_en), .out_bit(out_q[i]),
      .stk_clr(stk_clr[i]), .pend_clr(pend_clr[i]),
      .pad_o(pad_out[i]), .rd_bit(rd_bits[i]), .chg_o(chg_in[i]),
      .stk_hit(stk_hit[i]), .stk_keep(stk_keep[i]), .evt_set(evt_set[i]),
      .stk_o(stk_q[i]), .pend_o(evt_pend[i])
    );
  end

  assign pad_oe   = dir_q;
  assign evt_req  = |evt_pend;
  assign wake_hit = link_down & |(chg_in & wake_q & ~dir_q);

  always_ff @(posedge clk) begin
    if (rst) wake_req <= 1'b0;
    else     wake_req <= wake_hit;
  end

  always_comb begin
    case (reg_addr)
      AW'(ADR_DATA):  rd_sel = rd_bits;
      AW'(ADR_DIR):   rd_sel = dir_q;
      AW'(ADR_POL):   rd_sel = pol_q;
      AW'(ADR_LATCH): rd_sel = latch_q;
      AW'(ADR_MASK):  rd_sel = mask_q;
      AW'(ADR_WAKE):  rd_sel = wake_q;
      AW'(ADR_PEND):  rd_sel = evt_pend;
      default:        rd_sel = '0;
    endcase
  end

  assign reg_rdata = {{PADW{1'b0}}, rd_sel};
endmodule

// File: rtl/gpio8_event_chk.sv
module gpio8_event_chk #(
  parameter int NPIN = 8,
  parameter int DW   = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            unsol_en,
  input logic            link_down,
  input logic            evt_req,
  input logic            wake_req,
  input logic [DW-1:0]   reg_rdata,
  input logic [NPIN-1:0] evt_pend,
  input logic [NPIN-1:0] pend_clr,
  input logic [NPIN-1:0] stk_q,
  input logic [NPIN-1:0] stk_clr,
  input logic [NPIN-1:0] stk_keep,
  input logic [NPIN-1:0] dir_q
);
  // R8
  pend_hold_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((($past(evt_pend) & ~$past(pend_clr)) & ~evt_pend) == '0));

  // R7
  evt_gate_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(evt_req) |-> $past(unsol_en));

  // R9
  wake_gate_chk: assert property (@(posedge clk) disable iff (rst)
    wake_req |-> $past(link_down));

  // R2
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
    reg_rdata[DW-1:NPIN] == '0);

  // R6
  stk_hold_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((($past(stk_q) & ~$past(stk_clr) & $past(stk_keep)) & ~stk_q) == '0));

  // R10
  out_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((evt_pend & ~$past(evt_pend)) & $past(dir_q)) == '0));
endmodule

bind gpio8_event_port gpio8_event_chk #(.NPIN(NPIN), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .unsol_en(unsol_en), .link_down(link_down),
  .evt_req(evt_req), .wake_req(wake_req), .reg_rdata(reg_rdata),
  .evt_pend(evt_pend), .pend_clr(pend_clr), .stk_q(stk_q),
  .stk_clr(stk_clr), .stk_keep(stk_keep), .dir_q(dir_q)
);

// File: tb/gpio8_event_port_test.sv
module gpio8_event_port_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [7:0]  pad_in = '0;
  logic        unsol_en = 1'b0;
  logic        link_down = 1'b0;
  logic [7:0]  pad_out, pad_oe;
  logic        evt_req, wake_req;

  int checks = 0;
  int errs   = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  gpio8_event_port uut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
    .unsol_en(unsol_en), .link_down(link_down), .pad_out(pad_out),
    .pad_oe(pad_oe), .evt_req(evt_req), .wake_req(wake_req)
  );

  // kinds: 0 read word, 1 pad_out, 2 pad_oe, 3 evt_req, 4 wake_req
  typedef struct {
    int          kind;
    logic [31:0] exp;
    logic [31:0] msk;
    string       tag;
  } item_t;

  item_t sb_q[$];
  event  smp_ev;

  function automatic logic [31:0] pick(int kind);
    case (kind)
      0:       return reg_rdata;
      1:       return {24'h0, pad_out};
      2:       return {24'h0, pad_oe};
      3:       return {31'h0, evt_req};
      default: return {31'h0, wake_req};
    endcase
  endfunction

  // monitor: pops expected items and compares them with the outputs
  initial begin
    forever begin
      @(smp_ev);
      #1;
      while (sb_q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it  = sb_q.pop_front();
        act = pick(it.kind);
        checks++;
        if ((act & it.msk) !== (it.exp & it.msk)) begin
          errs++;
          $display("FAIL %s: actual %h expected %h", it.tag,
                   act & it.msk, it.exp & it.msk);
        end
      end
    end
  end

  task automatic push(int kind, logic [31:0] exp, logic [31:0] msk, string tag);
    item_t it;
    it.kind = kind; it.exp = exp; it.msk = msk; it.tag = tag;
    sb_q.push_back(it);
    ->smp_ev;
    #2;
  endtask

  task automatic chk_rd(logic [3:0] a, logic [31:0] exp, string tag);
    reg_addr = a;
    push(0, exp, 32'hFFFF_FFFF, tag);
  endtask

  task automatic chk_sig(int kind, logic [31:0] exp, logic [31:0] msk, string tag);
    push(kind, exp, msk, tag);
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errs++;
      $display("FAIL watchdog R1..: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    cyc(4);
    rst = 1'b0;

    // R1 reset state
    chk_rd(0, 32'h00, "R1 data");
    chk_rd(1, 32'h00, "R1 dir");
    chk_rd(2, 32'hFF, "R1 pol");
    chk_rd(3, 32'h00, "R1 latch mode");
    chk_rd(4, 32'h00, "R1 mask");
    chk_rd(5, 32'h00, "R1 wake");
    chk_rd(6, 32'h00, "R1 pend");
    chk_sig(2, 0, 32'hFF, "R1 pad_oe");
    chk_sig(3, 0, 1, "R1 evt_req");
    chk_sig(4, 0, 1, "R1 wake_req");

    // R2 register access
    wr(4, 32'hA5);
    chk_rd(4, 32'hA5, "R2 mask readback");
    wr(5, 32'hFFFF_FF5A);
    chk_rd(5, 32'h5A, "R2 upper bits dropped");
    chk_rd(9, 32'h0, "R2 unmapped address");
    wr(4, 0);
    wr(5, 0);

    // R3 output polarity
    wr(1, 32'h0F);
    wr(0, 32'h05);
    chk_sig(2, 32'h0F, 32'hFF, "R3 pad_oe");
    chk_sig(1, 32'h05, 32'h0F, "R3 pad_out pol1");
    wr(2, 32'hFC);
    chk_sig(1, 32'h06, 32'h0F, "R3 pad_out pol0");

    // R10 output read and no events
    chk_rd(0, 32'h05, "R10 output read");
    wr(4, 32'hFF);
    unsol_en = 1'b1;
    pad_in = 8'h0F;
    cyc(4);
    chk_sig(3, 0, 1, "R10 no evt on output");
    chk_rd(6, 32'h0, "R10 pend clear");
    unsol_en = 1'b0;
    pad_in = 8'h00;
    wr(4, 0);
    wr(1, 0);
    wr(2, 32'hFF);
    cyc(4);

    // R4 input sync latency and polarity
    pad_in = 8'h30;
    cyc(1);
    chk_rd(0, 32'h00, "R4 before sync");
    cyc(1);
    chk_rd(0, 32'h30, "R4 after sync");
    wr(2, 32'hEF);
    chk_rd(0, 32'h20, "R4 inverted bit4");
    wr(2, 32'hFF);

    // R5 latched inputs
    pad_in = 8'h32;
    cyc(4);
    wr(3, 32'h03);
    wr(2, 32'hFD);
    chk_rd(0, 32'h30, "R5 latches idle");
    pad_in = 8'h33;
    cyc(3);
    chk_rd(0, 32'h31, "R5 rising latched");
    pad_in = 8'h30;
    cyc(3);
    chk_rd(0, 32'h33, "R5 falling latched, opposite edge ignored");

    // R6 write-one-to-clear
    wr(0, 32'h01);
    chk_rd(0, 32'h32, "R6 clear bit0");
    wr(0, 32'h00);
    chk_rd(0, 32'h32, "R6 zero write no effect");
    wr(0, 32'h02);
    chk_rd(0, 32'h30, "R6 clear bit1");
    pad_in = 8'h31;
    cyc(2);
    wr(0, 32'h01);
    chk_rd(0, 32'h31, "R6 edge beats clear");
    wr(0, 32'h01);
    chk_rd(0, 32'h30, "R6 later clear");
    wr(3, 0);
    wr(2, 32'hFF);
    pad_in = 8'h00;
    cyc(4);
    chk_rd(0, 32'h00, "R4 plain input again");

    // R7 event gating
    wr(4, 32'h0C);
    unsol_en = 1'b1;
    pad_in = 8'h04;
    cyc(2);
    chk_sig(3, 0, 1, "R7 evt not yet");
    cyc(1);
    chk_sig(3, 1, 1, "R7 evt raised");
    chk_rd(6, 32'h04, "R7 pend bit2");
    pad_in = 8'h05;
    cyc(4);
    chk_rd(6, 32'h04, "R7 masked pin ignored");
    wr(6, 32'h04);
    chk_rd(6, 32'h00, "R8 ack");
    chk_sig(3, 0, 1, "R8 evt dropped");
    unsol_en = 1'b0;
    pad_in = 8'h0D;
    cyc(4);
    chk_rd(6, 32'h00, "R7 global disable");
    chk_sig(3, 0, 1, "R7 evt off when disabled");
    unsol_en = 1'b1;

    // R8 pending hold and ack race
    pad_in = 8'h01;
    cyc(3);
    chk_rd(6, 32'h0C, "R8 two pins pending");
    wr(6, 32'h08);
    chk_rd(6, 32'h04, "R8 partial ack");
    chk_sig(3, 1, 1, "R8 evt still high");
    pad_in = 8'h09;
    cyc(2);
    wr(6, 32'h0C);
    chk_rd(6, 32'h08, "R8 change beats ack");
    wr(6, 32'h00);
    chk_rd(6, 32'h08, "R8 zero write no effect");
    wr(6, 32'h08);
    chk_rd(6, 32'h00, "R8 final ack");
    chk_sig(3, 0, 1, "R8 evt low");

    // R9 wake pulse
    wr(5, 32'h10);
    link_down = 1'b1;
    pad_in = 8'h19;
    cyc(2);
    chk_sig(4, 0, 1, "R9 wake not yet");
    cyc(1);
    chk_sig(4, 1, 1, "R9 wake pulse");
    cyc(1);
    chk_sig(4, 0, 1, "R9 pulse one cycle");
    chk_rd(6, 32'h00, "R9 no event on unmasked wake pin");
    link_down = 1'b0;
    pad_in = 8'h09;
    cyc(3);
    chk_sig(4, 0, 1, "R9 link up no wake");
    cyc(1);
    link_down = 1'b1;
    pad_in = 8'h29;
    cyc(3);
    chk_sig(4, 0, 1, "R9 wake disabled pin");

    cyc(2);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule